// File: doc/BRIEF.md
# Accumulator-Feedback Logic and Arithmetic Unit

This block is an 8-bit logic and arithmetic unit whose result register is wired back as one of its two operands, so the result register behaves as an accumulator. The other operand is a byte presented on an input port. Each clock edge with the execute strobe high combines the operand byte with the accumulator using the selected opcode and writes the result back into the accumulator. The carry flag is written only by the add-with-carry operation.

Since the accumulator is always one operand, the usual single-register tasks are built from the basic operations. AND with zero clears the accumulator. OR with all ones sets it. XOR with all ones complements it. AND with all ones passes the value through. A constant is loaded by clearing and then ORing the constant in. A counter is built by clearing once and then incrementing repeatedly. Fetching instructions, holding memory and sequencing a program are left to the surrounding logic.

Top module: `accalu`

## Requirements
- R1: Asserting the active-low reset `rst_n` clears the accumulator and the carry flag to zero at once, without waiting for a clock edge.
- R2: On a rising clock edge with `exec_i` low, the accumulator and the carry flag keep their values, whatever the opcode and operand.
- R3: Opcode 1 (AND) loads the bitwise AND of the accumulator and the operand and leaves the carry unchanged. Operand 0x00 therefore clears the accumulator, and operand 0xFF leaves it unchanged.
- R4: Opcode 0 (OR) loads the bitwise OR of the accumulator and the operand and leaves the carry unchanged. Operand 0xFF sets every bit.
- R5: Opcode 2 (XOR) loads the bitwise XOR of the accumulator and the operand and leaves the carry unchanged. Operand 0xFF complements every bit.
- R6: Opcode 3 (increment) loads the accumulator plus one, modulo 256, so 0xFF wraps to 0x00. The carry flag keeps its previous value.
- R7: Opcode 4 (add with carry) forms the 9-bit sum of the accumulator, the operand and the current carry flag. Bits 7..0 of the sum go to the accumulator and bit 8 goes to the carry flag.
- R8: Opcodes 5, 6 and 7 leave the accumulator and the carry flag unchanged even when `exec_i` is high.
- R9: After one clear, repeated increments step the accumulator through the full 8-bit binary count and wrap from 0xFF back to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opnd_i | input | 8 | Operand byte combined with the accumulator |
| op_i | input | 3 | Opcode: 0 OR, 1 AND, 2 XOR, 3 increment, 4 add with carry, 5 to 7 no change |
| exec_i | input | 1 | Execute strobe; the operation takes effect on the next rising edge while it is high |
| acc_o | output | 8 | Accumulator value |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions check every cycle that an idle strobe or a no-change opcode holds both registers. They also check that each logic operation and the increment produce the value computed from the previous accumulator and operand while the carry stays put, and that add-with-carry yields the full 9-bit sum including the carry-in. Only the bench scenarios show that these operations compose correctly: loading a constant by clearing and ORing, a carry produced by one add and then consumed by a later one, the wrap of a long clear-then-increment count, and the immediate effect of an asynchronous reset in the middle of a run.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_OR  = 3'd0,
    OP_AND = 3'd1,
    OP_XOR = 3'd2,
    OP_INC = 3'd3,
    OP_ADC = 3'd4,
    OP_NOP = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    LF_OR  = 2'd0,
    LF_AND = 2'd1,
    LF_XOR = 2'd2,
    LF_OFF = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/accalu_ripple_add.sv
// Ripple-carry adder built from one full-adder cell per bit place.
module accalu_ripple_add #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = ci_i;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
    logic half_s;
    assign half_s      = a_i[gi] ^ b_i[gi];
    assign sum_o[gi]   = half_s ^ chain[gi];
    assign chain[gi+1] = (a_i[gi] & b_i[gi]) | (half_s & chain[gi]);
  end

  assign co_o = chain[WIDTH];

endmodule

// File: rtl/accalu_logic_unit.sv
// Bitwise two-input logic slice.
module accalu_logic_unit
  import accalu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      LF_OR:   res_o = a_i | b_i;
      LF_AND:  res_o = a_i & b_i;
      LF_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/accalu_datapath.sv
// Next-state logic: selects adder inputs and the value written back.
module accalu_datapath
  import accalu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic             carry_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] acc_d_o,
  output logic             carry_d_o
);

  logic [WIDTH-1:0] add_b;
  logic             add_ci;
  logic [WIDTH-1:0] add_sum;
  logic             add_co;
  logic [WIDTH-1:0] lu_res;
  logic_fn_e        lu_fn;

  // Operand steering for the shared adder: increment adds a carry-in of one.
  always_comb begin
    if (op_i == OP_INC) begin
      add_b  = '0;
      add_ci = 1'b1;
    end else begin
      add_b  = opnd_i;
      add_ci = carry_i;
    end
  end

  always_comb begin
    unique case (op_i)
      OP_OR:   lu_fn = LF_OR;
      OP_AND:  lu_fn = LF_AND;
      OP_XOR:  lu_fn = LF_XOR;
      default: lu_fn = LF_OFF;
    endcase
  end

  accalu_ripple_add #(.WIDTH(WIDTH)) u_add (
    .a_i   (acc_i),
    .b_i   (add_b),
    .ci_i  (add_ci),
    .sum_o (add_sum),
    .co_o  (add_co)
  );

  accalu_logic_unit #(.WIDTH(WIDTH)) u_lu (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .fn_i  (lu_fn),
    .res_o (lu_res)
  );

  always_comb begin
    acc_d_o   = acc_i;
    carry_d_o = carry_i;
    unique case (op_i)
      OP_OR, OP_AND, OP_XOR: acc_d_o = lu_res;
      OP_INC:                acc_d_o = add_sum;
      OP_ADC: begin
        acc_d_o   = add_sum;
        carry_d_o = add_co;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accalu.sv
// Accumulator-feedback logic/arithmetic unit: registers and checks.
module accalu
  import accalu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             exec_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o
);

  localparam int unsigned SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] acc_q, acc_d;
  logic             carry_q, carry_d;
  logic             upd_en;

  assign upd_en = exec_i;

  accalu_datapath #(.WIDTH(WIDTH)) u_dp (
    .acc_i     (acc_q),
    .carry_i   (carry_q),
    .opnd_i    (opnd_i),
    .op_i      (op_i),
    .acc_d_o   (acc_d),
    .carry_d_o (carry_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (upd_en) begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  // R2: idle strobe holds state
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(acc_o) && $stable(carry_o)));

  // R3: AND result, carry untouched
  a_r3_and: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_AND) |=>
      (acc_o == ($past(acc_o) & $past(opnd_i)) && $stable(carry_o)));

  // R4: OR result, carry untouched
  a_r4_or: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_OR) |=>
      (acc_o == ($past(acc_o) | $past(opnd_i)) && $stable(carry_o)));

  // R5: XOR result, carry untouched
  a_r5_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_XOR) |=>
      (acc_o == ($past(acc_o) ^ $past(opnd_i)) && $stable(carry_o)));

  // R6: increment wraps and keeps the carry
  a_r6_inc_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_INC) |=>
      (acc_o == WIDTH'($past(acc_o) + 1'b1) && $stable(carry_o)));

  // R7: full 9-bit sum with carry-in
  a_r7_adc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_ADC) |=>
      ({carry_o, acc_o} == (SUM_W'($past(acc_o)) + SUM_W'($past(opnd_i))
                            + SUM_W'($past(carry_o)))));

  // R8: opcodes 5..7 change nothing
  a_r8_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i >= OP_NOP) |=> ($stable(acc_o) && $stable(carry_o)));

endmodule

// File: tb/accalu_tb.sv
module accalu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  // {op[2:0], operand[7:0], expected acc[7:0], expected carry}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd0, 8'hFF, 8'hFF, 1'b0},  // R4 OR FF sets all bits
    {3'd4, 8'h01, 8'h00, 1'b1},  // R7 FF+01+0 carries out
    {3'd5, 8'h00, 8'h00, 1'b1},  // R8 opcode 5 holds
    {3'd3, 8'hAA, 8'h01, 1'b1},  // R6 increment keeps carry 1
    {3'd4, 8'h10, 8'h12, 1'b0},  // R7 01+10+carry-in 1
    {3'd2, 8'hFF, 8'hED, 1'b0},  // R5 XOR FF complements
    {3'd1, 8'h0F, 8'h0D, 1'b0},  // R3 AND mask
    {3'd1, 8'h00, 8'h00, 1'b0},  // R3 AND 00 clears
    {3'd0, 8'h05, 8'h05, 1'b0},  // R4 load constant by OR after clear
    {3'd1, 8'hFF, 8'h05, 1'b0},  // R3 AND FF passes through
    {3'd2, 8'hFF, 8'hFA, 1'b0},  // R5 complement
    {3'd6, 8'h33, 8'hFA, 1'b0},  // R8 opcode 6 holds
    {3'd7, 8'h12, 8'hFA, 1'b0},  // R8 opcode 7 holds
    {3'd4, 8'h06, 8'h00, 1'b1},  // R7 FA+06 carries out
    {3'd0, 8'hFF, 8'hFF, 1'b1},  // R4 OR keeps carry
    {3'd3, 8'h00, 8'h00, 1'b1},  // R6 FF wraps, carry kept
    {3'd2, 8'h3C, 8'h3C, 1'b1},  // R5 XOR pattern
    {3'd4, 8'hC3, 8'h00, 1'b1}   // R7 3C+C3+1 carries out
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] opnd_i;
  logic [2:0] op_i;
  logic       exec_i;
  logic [7:0] acc_o;
  logic       carry_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accalu #(.WIDTH(8)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .opnd_i  (opnd_i),
    .op_i    (op_i),
    .exec_i  (exec_i),
    .acc_o   (acc_o),
    .carry_o (carry_o)
  );

  task automatic check(input string req, input logic [7:0] exp_acc, input logic exp_c);
    n_vec++;
    if (acc_o !== exp_acc || carry_o !== exp_c) begin
      n_fail++;
      $display("FAIL %s: acc=%02h carry=%0b expected acc=%02h carry=%0b",
               req, acc_o, carry_o, exp_acc, exp_c);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] d, input logic ex);
    @(negedge clk);
    op_i   = op;
    opnd_i = d;
    exec_i = ex;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: acc=%02h carry=%0b expected run to finish", acc_o, carry_o);
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    opnd_i = 8'h00;
    op_i   = 3'd5;
    exec_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 8'h00, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][19:17], VEC[i][16:9], 1'b1);
      check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R2: strobe low ignores every opcode
    run_op(3'd0, 8'h5A, 1'b1);  // acc 5A, carry 1
    check("R4 OR into zero", 8'h5A, 1'b1);
    run_op(3'd4, 8'hFF, 1'b0);
    check("R2 idle add", 8'h5A, 1'b1);
    run_op(3'd1, 8'h00, 1'b0);
    check("R2 idle and", 8'h5A, 1'b1);
    run_op(3'd3, 8'h00, 1'b0);
    check("R2 idle increment", 8'h5A, 1'b1);

    // R7: add with carry-in 0 and no carry-out
    run_op(3'd1, 8'h00, 1'b1);
    run_op(3'd4, 8'h00, 1'b1);  // 00+00+1 -> 01, carry 0
    check("R7 carry-in consumed", 8'h01, 1'b0);
    run_op(3'd4, 8'h7E, 1'b1);
    check("R7 no carry-out", 8'h7F, 1'b0);

    // R9: clear then count through the full range and wrap
    run_op(3'd1, 8'h00, 1'b1);
    check("R9 clear", 8'h00, 1'b0);
    for (int k = 1; k <= 300; k++) begin
      run_op(3'd3, 8'h00, 1'b1);
      check("R9 count", 8'(k), 1'b0);
    end

    // R1: asynchronous reset mid-run
    run_op(3'd0, 8'hFF, 1'b1);
    run_op(3'd4, 8'h01, 1'b1);
    run_op(3'd0, 8'h81, 1'b1);
    check("R7 setup before reset", 8'h81, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(3'd3, 8'h00, 1'b1);
    check("R1 operation after reset", 8'h01, 1'b0);

    finish_run();
  end

endmodule